// File: doc/BRIEF.md
# Per-Bit Data Eye Edge Search

This block is a calibration sequencer for one group of data bits that share a delay setting. It walks a delay tap upward one step at a time. At each step it asks an outside test engine for a pass/fail verdict on every bit. From those verdicts it builds, for each bit, a signed pair of edge values that describe where that bit's passing window lies.

One operation runs two sweeps back to back. The first sweep moves the data delay upward from zero and finds where each bit starts to pass. The second sweep moves the strobe delay upward from a programmable start point and finds where each bit stops passing. A window that already begins below the first tested tap is shown by a negative edge value. A companion enable delay can follow the strobe delay, limited to its own ceiling.

After both sweeps, the block pulses `done` with a status code. The code is zero when every bit has a full window. Otherwise it names the first bit that lacks one. The memory traffic, the pass/fail test and the delay lines are all outside the block.

Top module: `eye_edge_search`

## Requirements
- R1: While reset is high, and when an operation starts, every bit's left and right edge is set to the sentinel MAX_DLY+1. After reset, `done`, `test_req` and `res_ready` are low and `status` is 0.
- R2: For every tested tap, `test_req` is high for exactly one cycle, and `res_ready` is high from that cycle until a result is taken. A result is taken on a clock edge where `res_valid` and `res_ready` are both high. The delay outputs stay stable from the request until the result is taken.
- R3: In the data sweep (`sweep_sel`=0), a bit with `res_pass` bit = 1 records the current tap as its left edge.
- R4: In the data sweep, a failing bit that has no left edge yet records -(tap+1) as its right edge. When the data sweep ends, a bit with no left edge gets its right edge set back to the sentinel.
- R5: A running accumulated mask is the OR of all results taken. A sweep ends after the first taken result that makes this mask all ones, or after its last tap, whichever comes first.
- R6: When the data sweep ends, the accumulated mask is rebuilt. With `wr_mode`=1, a bit is set when it has a left edge. With `wr_mode`=0, a bit is set only when it has both edges.
- R7: The data sweep applies taps 0 to MAX_DLY on `dly_out`. The strobe sweep (`sweep_sel`=1) uses taps 0 to MAX_DLY−`strobe_start` and drives `dly_out` = tap+`strobe_start`.
- R8: In the strobe sweep, a passing bit records the tap as its right edge. When the tap is above 0, a failing bit with no right edge records -(tap+1) as its left edge.
- R9: At strobe tap 0, a failing bit with no right edge is handled by one of two rules. If it has a left edge, it gets right edge -1. If it has no left edge, it gets left edge -1.
- R10: `en_dly_out` equals min(`en_start`+tap, EN_MAX) during the strobe sweep when `track_en`=1. Otherwise it equals min(`en_start`, EN_MAX).
- R11: At the end, `done` is high for one cycle. With it, `status` gives index+1 of the lowest-numbered bit whose left or right edge is still the sentinel, or 0 if there is no such bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when idle) |
| wr_mode | input | 1 | Mask rebuild rule: 1 write-style, 0 read-style |
| strobe_start | input | TAP_W | Base delay of the strobe sweep |
| en_start | input | EN_W | Base value of the companion enable delay |
| track_en | input | 1 | Enable delay follows the strobe tap |
| test_req | output | 1 | One-cycle request for a test at the current delay |
| res_valid | input | 1 | Test result available |
| res_ready | output | 1 | Block waits for a result |
| res_pass | input | NBITS | Per-bit pass flags of the result |
| sweep_sel | output | 1 | 0 data sweep, 1 strobe sweep |
| dly_out | output | TAP_W | Delay value applied to the lines |
| en_dly_out | output | EN_W | Companion enable delay |
| done | output | 1 | End-of-operation pulse |
| status | output | SW | 0 on success, otherwise index+1 of the first bit without a window |
| left_edges | output | NBITS*EW | Signed left edge per bit, bit i at [i*EW +: EW] |
| right_edges | output | NBITS*EW | Signed right edge per bit, bit i at [i*EW +: EW] |

## Verification
The assertions assume that the test engine raises `res_valid` only after a request and keeps it high until the result is taken. They also assume that `strobe_start` never exceeds MAX_DLY, so the strobe sweep's last tap is not negative. The stimulus meets both assumptions. A responder answers each request two cycles later and drops `res_valid` as soon as it sees `res_ready` fall. Every start value used in the scenarios lies inside the delay range. The pass pattern is modelled as a per-bit window that shifts with the bit index, with some bits optionally dead. This brings out early stops, negative edges, the marginal tap-0 rules and failure codes.

// File: rtl/ees_pkg.sv
package ees_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_WAIT,
    ST_FIX,
    ST_RPT
  } ees_state_t;

  // saturating sum used for the companion enable delay
  function automatic int sat_sum(input int a, input int b, input int lim);
    int s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

endpackage

// File: rtl/ees_lane.sv
module ees_lane #(
  parameter int MAX_DLY = 15,
  parameter int TAP_W   = 4,
  parameter int EW      = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init,
  input  logic                 upd,
  input  logic                 fix,
  input  logic                 phase,
  input  logic [TAP_W-1:0]     tap,
  input  logic                 pass,
  output logic signed [EW-1:0] left_q,
  output logic signed [EW-1:0] right_q,
  output logic                 has_left,
  output logic                 has_right
);

  localparam logic signed [EW-1:0] SENT   = EW'(MAX_DLY + 1);
  localparam logic signed [EW-1:0] MINUS1 = '1;

  logic signed [EW-1:0] tap_s;
  logic signed [EW-1:0] miss_code;

  assign tap_s     = $signed({{(EW-TAP_W){1'b0}}, tap});
  assign miss_code = ~tap_s;  // two's complement: equals -(tap+1)
  assign has_left  = (left_q  != SENT);
  assign has_right = (right_q != SENT);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      left_q  <= SENT;
      right_q <= SENT;
    end else if (fix) begin
      if (!has_left) right_q <= SENT;
    end else if (upd) begin
      if (!phase) begin
        if (pass)           left_q  <= tap_s;
        else if (!has_left) right_q <= miss_code;
      end else begin
        if (pass) begin
          right_q <= tap_s;
        end else if (tap != '0) begin
          if (!has_right) left_q <= miss_code;
        end else if (!has_right) begin
          if (has_left) right_q <= MINUS1;
          else          left_q  <= MINUS1;
        end
      end
    end
  end

  // R4
  fix_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fix && !has_left) |=> (right_q == SENT));

  // R3
  edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (left_q <= SENT) && (left_q >= -SENT) && (right_q <= SENT) && (right_q >= -SENT));

  // R9
  marginal_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && phase && (tap == '0) && !pass && has_left && !has_right) |=> (right_q == MINUS1));

endmodule

// File: rtl/ees_report.sv
module ees_report #(
  parameter int NBITS = 8,
  parameter int SW    = 4
) (
  input  logic [NBITS-1:0] has_left,
  input  logic [NBITS-1:0] has_right,
  output logic [SW-1:0]    first_miss
);

  always_comb begin
    first_miss = '0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (!(has_left[i] && has_right[i])) first_miss = SW'(i + 1);
    end
  end

endmodule

// File: rtl/ees_ctrl.sv
module ees_ctrl
  import ees_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int MAX_DLY = 15,
  parameter int EN_MAX  = 5,
  parameter int TAP_W   = 4,
  parameter int EN_W    = 3,
  parameter int SW      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wr_mode,
  input  logic [TAP_W-1:0] strobe_start,
  input  logic [EN_W-1:0]  en_start,
  input  logic             track_en,
  input  logic             res_valid,
  input  logic [NBITS-1:0] res_pass,
  input  logic [NBITS-1:0] has_left,
  input  logic [NBITS-1:0] has_right,
  input  logic [SW-1:0]    first_miss,
  output logic             lane_init,
  output logic             lane_upd,
  output logic             lane_fix,
  output logic             phase_q,
  output logic [TAP_W-1:0] tap_q,
  output logic [TAP_W-1:0] dly_q,
  output logic [EN_W-1:0]  en_q,
  output logic             req_q,
  output logic             rdy_q,
  output logic             done_q,
  output logic [SW-1:0]    status_q
);

  localparam logic [NBITS-1:0] ALL = {NBITS{1'b1}};

  ees_state_t       state;
  logic [NBITS-1:0] sticky_q;
  logic [TAP_W-1:0] ss_q;
  logic [EN_W-1:0]  es_q;
  logic             trk_q;
  logic             wr_q;

  logic [TAP_W-1:0] last;
  logic [TAP_W-1:0] tap_n;
  logic [NBITS-1:0] merged;
  logic [NBITS-1:0] keep;
  logic             stop;

  assign last      = phase_q ? (TAP_W'(MAX_DLY) - ss_q) : TAP_W'(MAX_DLY);
  assign tap_n     = tap_q + 1'b1;
  assign merged    = sticky_q | res_pass;
  assign stop      = (merged == ALL) || (tap_q == last);
  assign keep      = wr_q ? has_left : (has_left & has_right);
  assign lane_init = (state == ST_IDLE) && start;
  assign lane_upd  = (state == ST_WAIT) && rdy_q && res_valid;
  assign lane_fix  = (state == ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sticky_q <= '0;
      ss_q     <= '0;
      es_q     <= '0;
      trk_q    <= 1'b0;
      wr_q     <= 1'b0;
      phase_q  <= 1'b0;
      tap_q    <= '0;
      dly_q    <= '0;
      en_q     <= '0;
      req_q    <= 1'b0;
      rdy_q    <= 1'b0;
      done_q   <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ss_q     <= strobe_start;
            es_q     <= en_start;
            trk_q    <= track_en;
            wr_q     <= wr_mode;
            phase_q  <= 1'b0;
            tap_q    <= '0;
            dly_q    <= '0;
            en_q     <= EN_W'(sat_sum(int'(en_start), 0, EN_MAX));
            sticky_q <= '0;
            state    <= ST_SET;
          end
        end
        ST_SET: begin
          req_q <= 1'b1;
          rdy_q <= 1'b1;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          req_q <= 1'b0;
          if (lane_upd) begin
            sticky_q <= merged;
            rdy_q    <= 1'b0;
            if (stop) begin
              state <= phase_q ? ST_RPT : ST_FIX;
            end else begin
              tap_q <= tap_n;
              state <= ST_SET;
              if (phase_q) begin
                dly_q <= tap_n + ss_q;
                en_q  <= EN_W'(sat_sum(int'(es_q), trk_q ? int'(tap_n) : 0, EN_MAX));
              end else begin
                dly_q <= tap_n;
              end
            end
          end
        end
        ST_FIX: begin
          sticky_q <= keep;
          phase_q  <= 1'b1;
          tap_q    <= '0;
          dly_q    <= ss_q;
          en_q     <= EN_W'(sat_sum(int'(es_q), 0, EN_MAX));
          state    <= ST_SET;
        end
        ST_RPT: begin
          status_q <= first_miss;
          done_q   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst) req_q |=> !req_q);

  // R2
  ready_wait_chk: assert property (@(posedge clk) disable iff (rst) rdy_q |-> (state == ST_WAIT));

  // R7
  tap_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (tap_q <= last));

  // R7
  strobe_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q && (state == ST_WAIT)) |-> (dly_q == tap_q + ss_q));

  // R10
  en_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (en_q <= EN_W'(EN_MAX)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);

  // R5
  sticky_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_upd && !stop) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

endmodule

// File: rtl/eye_edge_search.sv
module eye_edge_search #(
  parameter  int NBITS   = 8,
  parameter  int MAX_DLY = 15,
  parameter  int EN_MAX  = 5,
  localparam int TAP_W   = $clog2(MAX_DLY + 1),
  localparam int EW      = TAP_W + 2,
  localparam int EN_W    = $clog2(EN_MAX + 1),
  localparam int SW      = $clog2(NBITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                wr_mode,
  input  logic [TAP_W-1:0]    strobe_start,
  input  logic [EN_W-1:0]     en_start,
  input  logic                track_en,
  output logic                test_req,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [NBITS-1:0]    res_pass,
  output logic                sweep_sel,
  output logic [TAP_W-1:0]    dly_out,
  output logic [EN_W-1:0]     en_dly_out,
  output logic                done,
  output logic [SW-1:0]       status,
  output logic [NBITS*EW-1:0] left_edges,
  output logic [NBITS*EW-1:0] right_edges
);

  logic             lane_init, lane_upd, lane_fix, phase_q;
  logic [TAP_W-1:0] tap_q;
  logic [NBITS-1:0] has_left, has_right;
  logic [SW-1:0]    first_miss;

  ees_ctrl #(
    .NBITS(NBITS), .MAX_DLY(MAX_DLY), .EN_MAX(EN_MAX),
    .TAP_W(TAP_W), .EN_W(EN_W), .SW(SW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .wr_mode(wr_mode),
    .strobe_start(strobe_start), .en_start(en_start), .track_en(track_en),
    .res_valid(res_valid), .res_pass(res_pass),
    .has_left(has_left), .has_right(has_right), .first_miss(first_miss),
    .lane_init(lane_init), .lane_upd(lane_upd), .lane_fix(lane_fix),
    .phase_q(phase_q), .tap_q(tap_q), .dly_q(dly_out), .en_q(en_dly_out),
    .req_q(test_req), .rdy_q(res_ready), .done_q(done), .status_q(status)
  );

  for (genvar g = 0; g < NBITS; g++) begin : g_lane
    logic signed [EW-1:0] l_q, r_q;
    ees_lane #(.MAX_DLY(MAX_DLY), .TAP_W(TAP_W), .EW(EW)) u_lane (
      .clk(clk), .rst(rst), .init(lane_init), .upd(lane_upd), .fix(lane_fix),
      .phase(phase_q), .tap(tap_q), .pass(res_pass[g]),
      .left_q(l_q), .right_q(r_q), .has_left(has_left[g]), .has_right(has_right[g])
    );
    assign left_edges[g*EW +: EW]  = l_q;
    assign right_edges[g*EW +: EW] = r_q;
  end

  ees_report #(.NBITS(NBITS), .SW(SW)) u_report (
    .has_left(has_left), .has_right(has_right), .first_miss(first_miss)
  );

  assign sweep_sel = phase_q;

endmodule

// File: tb/eye_edge_search_test.sv
module eye_edge_search_test;

  localparam int NB = 8;
  localparam int MX = 15;
  localparam int EM = 5;
  localparam int TW = 4;
  localparam int EW = 6;
  localparam int ENW = 3;
  localparam int SWD = 4;
  localparam int SENT = MX + 1;

  typedef struct packed {
    logic       wr;
    logic [3:0] ss;
    logic [2:0] es;
    logic       trk;
    logic [4:0] lo0;
    logic [4:0] hi0;
    logic [4:0] lo1;
    logic [4:0] hi1;
    logic [1:0] skew;
    logic [7:0] dead;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 4'd2, 3'd3, 1'b1, 5'd3, 5'd9,  5'd2,  5'd10, 2'd0, 8'h00},
    '{1'b1, 4'd0, 3'd6, 1'b1, 5'd0, 5'd5,  5'd3,  5'd12, 2'd1, 8'h00},
    '{1'b0, 4'd5, 3'd1, 1'b1, 5'd2, 5'd8,  5'd6,  5'd9,  2'd1, 8'h20},
    '{1'b1, 4'd3, 3'd0, 1'b0, 5'd4, 5'd7,  5'd0,  5'd4,  2'd2, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wr_mode = 1'b0;
  logic [TW-1:0] strobe_start = '0;
  logic [ENW-1:0] en_start = '0;
  logic track_en = 1'b0;
  logic test_req;
  logic res_valid = 1'b0;
  logic res_ready;
  logic [NB-1:0] res_pass = '0;
  logic sweep_sel;
  logic [TW-1:0] dly_out;
  logic [ENW-1:0] en_dly_out;
  logic done;
  logic [SWD-1:0] status;
  logic [NB*EW-1:0] left_edges, right_edges;

  always #4 clk = ~clk;  // 125 MHz

  eye_edge_search uut (
    .clk(clk), .rst(rst), .start(start), .wr_mode(wr_mode),
    .strobe_start(strobe_start), .en_start(en_start), .track_en(track_en),
    .test_req(test_req), .res_valid(res_valid), .res_ready(res_ready),
    .res_pass(res_pass), .sweep_sel(sweep_sel), .dly_out(dly_out),
    .en_dly_out(en_dly_out), .done(done), .status(status),
    .left_edges(left_edges), .right_edges(right_edges)
  );

  int checks = 0;
  int errors = 0;
  vec_t cur;
  int n0s, n1s;
  int exp_l [NB];
  int exp_r [NB];
  int exp_n0, exp_n1, exp_st;

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] pv(input vec_t v, input int ph, input int d);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) begin
      int lo, hi;
      lo = (ph != 0 ? int'(v.lo1) : int'(v.lo0)) + i * int'(v.skew);
      hi = (ph != 0 ? int'(v.hi1) : int'(v.hi0)) + i * int'(v.skew);
      p[i] = !v.dead[i] && (d >= lo) && (d <= hi);
    end
    return p;
  endfunction

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // expectations from the requirements
  task automatic ref_model(input vec_t v);
    logic [NB-1:0] st, p;
    int ss;
    ss = int'(v.ss);
    for (int i = 0; i < NB; i++) begin exp_l[i] = SENT; exp_r[i] = SENT; end
    st = '0; exp_n0 = 0;
    for (int d = 0; d <= MX; d++) begin
      exp_n0++;
      p = pv(v, 0, d);
      st |= p;
      for (int i = 0; i < NB; i++) begin
        if (p[i]) exp_l[i] = d;
        else if (exp_l[i] == SENT) exp_r[i] = -(d + 1);
      end
      if (st == '1) break;
    end
    for (int i = 0; i < NB; i++) begin
      if (exp_l[i] == SENT) exp_r[i] = SENT;
      st[i] = v.wr ? (exp_l[i] != SENT) : ((exp_l[i] != SENT) && (exp_r[i] != SENT));
    end
    exp_n1 = 0;
    for (int t = 0; t <= MX - ss; t++) begin
      exp_n1++;
      p = pv(v, 1, ss + t);
      st |= p;
      for (int i = 0; i < NB; i++) begin
        if (p[i]) exp_r[i] = t;
        else if (t != 0) begin
          if (exp_r[i] == SENT) exp_l[i] = -(t + 1);
        end else if (exp_r[i] == SENT) begin
          if (exp_l[i] != SENT) exp_r[i] = -1;
          else exp_l[i] = -1;
        end
      end
      if (st == '1) break;
    end
    exp_st = 0;
    for (int i = NB - 1; i >= 0; i--)
      if (exp_l[i] == SENT || exp_r[i] == SENT) exp_st = i + 1;
  endtask

  // test engine model: answers each request two cycles later
  initial begin
    int wt;
    int ph;
    logic pulse_chk;
    wt = 0; ph = 0; pulse_chk = 1'b0;
    forever begin
      @(negedge clk);
      if (pulse_chk) begin
        check(int'(test_req), 0, "R2 request pulse width");
        pulse_chk = 1'b0;
      end
      if (res_valid && !res_ready) res_valid = 1'b0;
      if (test_req && !rst) begin
        ph = int'(sweep_sel);
        pulse_chk = 1'b1;
        check(int'(res_ready), 1, "R2 ready with request");
        if (ph == 0) begin
          check(int'(dly_out), n0s, "R7 data sweep delay");
          n0s++;
        end else begin
          check(int'(dly_out), int'(cur.ss) + n1s, "R7 strobe sweep delay");
          check(int'(en_dly_out),
                cur.trk ? mn(int'(cur.es) + n1s, EM) : mn(int'(cur.es), EM),
                "R10 enable delay");
          n1s++;
        end
        wt = 2;
      end else if (wt > 0) begin
        wt--;
        if (wt == 0) begin
          res_pass = pv(cur, ph, int'(dly_out));
          res_valid = 1'b1;
        end
      end
    end
  end

  task automatic run_vec(input vec_t v);
    ref_model(v);
    cur = v; n0s = 0; n1s = 0;
    @(negedge clk);
    wr_mode = v.wr; strobe_start = v.ss; en_start = v.es; track_en = v.trk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(int'(status), exp_st, "R11 status code");
    check(n0s, exp_n0, "R5 data sweep tap count");
    check(n1s, exp_n1, "R6 R7 strobe sweep tap count");
    for (int i = 0; i < NB; i++) begin
      check(int'($signed(left_edges[i*EW +: EW])), exp_l[i], "R3 R8 R9 left edge");
      check(int'($signed(right_edges[i*EW +: EW])), exp_r[i], "R4 R8 R9 right edge");
    end
    @(negedge clk);
    check(int'(done), 0, "R11 done single cycle");
  endtask

  task automatic reset_check();
    check(int'(done), 0, "R1 done after reset");
    check(int'(test_req), 0, "R1 request after reset");
    check(int'(res_ready), 0, "R1 ready after reset");
    check(int'(status), 0, "R1 status after reset");
    for (int i = 0; i < NB; i++) begin
      check(int'($signed(left_edges[i*EW +: EW])), SENT, "R1 left sentinel");
      check(int'($signed(right_edges[i*EW +: EW])), SENT, "R1 right sentinel");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t d1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    reset_check();
    for (int k = 0; k < NV; k++) run_vec(VECS[k]);
    // R9: tap-0 marginal bits, read-style rebuild keeps nothing
    d1 = '{1'b0, 4'd4, 3'd2, 1'b0, 5'd0, 5'd6, 5'd31, 5'd31, 2'd0, 8'h00};
    run_vec(d1);
    // R6: write-style rebuild keeps bits with a left edge, strobe sweep stops at once
    d1.wr = 1'b1;
    run_vec(d1);
    // R9: dead bit with no edges at strobe tap 0
    d1 = '{1'b0, 4'd1, 3'd7, 1'b1, 5'd1, 5'd3, 5'd2, 5'd5, 2'd0, 8'h04};
    run_vec(d1);
    // R1: reset after a run restores sentinels
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    reset_check();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule